// File: doc/BRIEF.md
# Cascaded Interrupt Resolver

This block collects interrupt requests from three kinds of source and names the one that should be served next. Thirty-two top-level lines form the first level. Most of them are plain sources, but five are cascade lines. Four of them each summarise a group of thirty-two general-purpose pin requests, and one summarises six DMA channel requests. Every source has its own sticky pending bit and its own enable bit. The block searches both levels and presents a single flat interrupt number, so the handler never has to walk the cascade itself.

Software changes enables and clears pending bits through a small write port. Enables use write-one-to-set and write-one-to-clear strobes, so no read-modify-write is needed. The enable of a cascade line is not stored anywhere: it is on whenever at least one of its children is enabled. The resolved number and a valid flag leave the block from a register. When nothing is requested, the block reports the all-ones code.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: Reset (synchronous, `rst_n` low) clears every pending and enable bit, drives `irq_valid` to 0 and `irq_num` to 8'hFF. A source pulsed after reset is not reported until it is enabled.
- R2: `wr_addr[4:3]` selects the operation: 0 sets enable bits, 1 clears enable bits, 2 acknowledges (clears pending bits), and 3 has no effect. `wr_addr[2:0]` selects the bank: 0 is the direct top-level bank, 1 is the DMA bank, and 2+g is pin group g. Banks 6 and 7 have no effect.
- R3: A source that is high at a clock edge sets its pending bit, even while it is disabled. The bit stays set until it is acknowledged. An acknowledge in the same cycle as a high source leaves the bit set.
- R4: A direct top-level source at index i (any index other than 20 and 25..28) is reported as flat number i.
- R5: Across the top level, the lowest-indexed line that is both pending and enabled wins. For example, direct bit 5 beats DMA line 20, and DMA line 20 beats group line 28.
- R6: Pin group g drives top-level line 28−g. The flat number of pin p in group g is 48 + 32·g + p, and the lowest enabled pending pin in the group wins.
- R7: The six DMA channels share top-level line 20. The flat number is 32 plus the lowest enabled pending channel.
- R8: A cascade line counts as enabled only while at least one of its children is enabled. Enable writes, acknowledges and `irq_src` bits at top-level positions 20 and 25..28 are ignored.
- R9: When no source is both pending and enabled, `irq_valid` is 0 and `irq_num` is 8'hFF.
- R10: `irq_valid` and `irq_num` reflect the pending and enable state one clock after that state changes. A source sampled at edge k is first visible after edge k+1.
- R11: Acknowledging the last enabled pending pin of a group drops that group's top-level line, so the next requester becomes visible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | 32 | Direct top-level requests, sampled each edge |
| dma_src | input | 6 | DMA channel requests |
| gpio_src | input | 128 | Pin requests; bit 32·g+p is pin p of group g |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 5 | {operation[1:0], bank[2:0]} |
| wr_data | input | 32 | Bit mask for the selected bank |
| irq_valid | output | 1 | A source is pending and enabled |
| irq_num | output | 8 | Flat number of the winning source, 8'hFF when none |

## Verification
The properties assume that `wr_en`, `wr_addr` and the source inputs are driven to known values from the first clock, and that a write carries one operation for one bank per cycle. The properties on acknowledge also assume that a source being cleared is not high in the same cycle. The stimulus changes inputs only on falling edges. It issues at most one write per cycle and pulses each source for a single cycle, except in the one directed case that holds a source high on purpose during an acknowledge.

// File: rtl/cic_pkg.sv
// Package: shared encodings for the cascaded interrupt resolver.
// Assumes: write address is {op[1:0], bank[2:0]}.
package cic_pkg;
    typedef enum logic [1:0] {
        OP_EN_SET = 2'd0,
        OP_EN_CLR = 2'd1,
        OP_ACK    = 2'd2,
        OP_NONE   = 2'd3
    } cic_op_e;

    localparam int          BANK_W      = 3;
    localparam int          OP_W        = 2;
    localparam int          ADDR_W      = OP_W + BANK_W;
    localparam logic [2:0]  BANK_DIRECT = 3'd0;
    localparam logic [2:0]  BANK_DMA    = 3'd1;
    localparam logic [2:0]  BANK_GPIO0  = 3'd2;
endpackage

// File: rtl/cic_lsb_find.sv
// Module: lowest-set-bit finder.
// Does: reports whether any bit of vec is set and the index of the lowest one.
// Assumes: W >= 1; idx is 0 when nothing is set.
module cic_lsb_find #(
    parameter int W  = 32,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top down so the lowest set bit is the last one written.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/cic_bank.sv
// Module: one bank of sticky pending bits with enable bits.
// Does: latches high sources into pending, clears on acknowledge, and sets or
//       clears enables by write-one strobes.
// Assumes: sel is high for one cycle per write; op is decoded here.
module cic_bank
    import cic_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         sel,
    input  cic_op_e      op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pend,
    output logic [W-1:0] en
);
    logic [W-1:0] set_m, clr_m, ack_m;

    // Turn the write into per-bit strobes for the selected operation.
    always_comb begin
        set_m = (sel && op == OP_EN_SET) ? wdata : '0;
        clr_m = (sel && op == OP_EN_CLR) ? wdata : '0;
        ack_m = (sel && op == OP_ACK)    ? wdata : '0;
    end

    // Update the pending and enable state; a live source wins over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            en   <= '0;
        end else begin
            pend <= (pend & ~ack_m) | src;
            en   <= (en | set_m) & ~clr_m;
        end
    end
endmodule

// File: rtl/cic_resolver.sv
// Module: two-level priority resolver.
// Does: picks the lowest requesting top-level line and, for a cascade line,
//       the lowest requesting child, and forms the flat number.
// Assumes: requests are already gated by enables; all-ones means none.
module cic_resolver #(
    parameter int DATA_W    = 32,
    parameter int NUM_GRP   = 4,
    parameter int NUM_DMA   = 6,
    parameter int GPIO_TOP0 = 28,
    parameter int DMA_TOP   = 20,
    parameter int DMA_BASE  = 32,
    parameter int GPIO_BASE = 48,
    parameter int NUM_W     = 8
) (
    input  logic [DATA_W-1:0]         top_req,
    input  logic [NUM_GRP*DATA_W-1:0] grp_req,
    input  logic [NUM_DMA-1:0]        dma_req,
    output logic                      hit,
    output logic [NUM_W-1:0]          num
);
    localparam int TIW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int DIW = (NUM_DMA > 1) ? $clog2(NUM_DMA) : 1;

    logic           top_found, dma_found;
    logic [TIW-1:0] top_idx;
    logic [DIW-1:0] dma_idx;
    logic [TIW-1:0] grp_idx   [NUM_GRP];
    logic           grp_found [NUM_GRP];

    cic_lsb_find #(.W(DATA_W)) top_find_i (
        .vec(top_req), .found(top_found), .idx(top_idx)
    );

    cic_lsb_find #(.W(NUM_DMA)) dma_find_i (
        .vec(dma_req), .found(dma_found), .idx(dma_idx)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        cic_lsb_find #(.W(DATA_W)) grp_find_i (
            .vec(grp_req[g*DATA_W +: DATA_W]),
            .found(grp_found[g]),
            .idx(grp_idx[g])
        );
    end

    // Translate the winning top-level line into a flat number.
    always_comb begin
        hit = top_found;
        num = '1;
        if (top_found) begin
            num = NUM_W'(int'(top_idx));
            if (int'(top_idx) == DMA_TOP && dma_found)
                num = NUM_W'(DMA_BASE + int'(dma_idx));
            for (int g = 0; g < NUM_GRP; g++) begin
                if (int'(top_idx) == GPIO_TOP0 - g && grp_found[g])
                    num = NUM_W'(GPIO_BASE + g * DATA_W + int'(grp_idx[g]));
            end
        end
    end
endmodule

// File: rtl/cascade_irq_ctrl.sv
// Module: cascaded interrupt controller, top level.
// Does: holds the direct, DMA and pin-group banks, derives the cascade lines,
//       and registers the resolved flat number and valid flag.
// Assumes: one write per cycle; cascade positions in the direct bank are unused.
module cascade_irq_ctrl
    import cic_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_GRP   = 4,
    parameter int NUM_DMA   = 6,
    parameter int GPIO_TOP0 = 28,
    parameter int DMA_TOP   = 20,
    parameter int DMA_BASE  = 32,
    parameter int GPIO_BASE = 48,
    localparam int GPIO_N   = NUM_GRP * DATA_W,
    localparam int NUM_END  = GPIO_BASE + GPIO_N,
    localparam int NUM_W    = $clog2(NUM_END + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] irq_src,
    input  logic [NUM_DMA-1:0] dma_src,
    input  logic [GPIO_N-1:0] gpio_src,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq_valid,
    output logic [NUM_W-1:0]  irq_num
);
    // Build the set of top-level positions taken by cascade lines.
    function automatic logic [DATA_W-1:0] casc_mask_f();
        logic [DATA_W-1:0] m;
        m = '0;
        m[DMA_TOP] = 1'b1;
        for (int g = 0; g < NUM_GRP; g++) m[GPIO_TOP0 - g] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] CASC_MASK = casc_mask_f();

    cic_op_e            op;
    logic [BANK_W-1:0]  bank;
    logic               sel_direct, sel_dma;
    logic [NUM_GRP-1:0] sel_grp;

    logic [DATA_W-1:0]  top_pend, top_en;
    logic [NUM_DMA-1:0] dma_pend, dma_en;
    logic [DATA_W-1:0]  gpio_pend [NUM_GRP];
    logic [DATA_W-1:0]  gpio_en   [NUM_GRP];
    logic [NUM_GRP-1:0] grp_en_any;

    logic [DATA_W-1:0]  top_req;
    logic [GPIO_N-1:0]  grp_req;
    logic [NUM_DMA-1:0] dma_req;
    logic               res_hit;
    logic [NUM_W-1:0]   res_num;

    // Split the write address into operation and bank selects.
    always_comb begin
        op         = cic_op_e'(wr_addr[ADDR_W-1 -: OP_W]);
        bank       = wr_addr[BANK_W-1:0];
        sel_direct = wr_en && (bank == BANK_DIRECT);
        sel_dma    = wr_en && (bank == BANK_DMA);
        for (int g = 0; g < NUM_GRP; g++)
            sel_grp[g] = wr_en && (int'(bank) == int'(BANK_GPIO0) + g);
    end

    cic_bank #(.W(DATA_W)) direct_bank_i (
        .clk(clk), .rst_n(rst_n),
        .src(irq_src & ~CASC_MASK),
        .sel(sel_direct), .op(op),
        .wdata(wr_data & ~CASC_MASK),
        .pend(top_pend), .en(top_en)
    );

    cic_bank #(.W(NUM_DMA)) dma_bank_i (
        .clk(clk), .rst_n(rst_n),
        .src(dma_src),
        .sel(sel_dma), .op(op),
        .wdata(wr_data[NUM_DMA-1:0]),
        .pend(dma_pend), .en(dma_en)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_gpio
        cic_bank #(.W(DATA_W)) gpio_bank_i (
            .clk(clk), .rst_n(rst_n),
            .src(gpio_src[g*DATA_W +: DATA_W]),
            .sel(sel_grp[g]), .op(op),
            .wdata(wr_data),
            .pend(gpio_pend[g]), .en(gpio_en[g])
        );
    end

    // Gate every level by its enables and merge the cascade lines on top.
    always_comb begin
        dma_req = dma_pend & dma_en;
        top_req = top_pend & top_en & ~CASC_MASK;
        top_req[DMA_TOP] = (|dma_en) && (|dma_req);
        for (int g = 0; g < NUM_GRP; g++) begin
            grp_en_any[g] = |gpio_en[g];
            grp_req[g*DATA_W +: DATA_W] = gpio_pend[g] & gpio_en[g];
            top_req[GPIO_TOP0 - g] = grp_en_any[g] && (|grp_req[g*DATA_W +: DATA_W]);
        end
    end

    cic_resolver #(
        .DATA_W(DATA_W), .NUM_GRP(NUM_GRP), .NUM_DMA(NUM_DMA),
        .GPIO_TOP0(GPIO_TOP0), .DMA_TOP(DMA_TOP),
        .DMA_BASE(DMA_BASE), .GPIO_BASE(GPIO_BASE), .NUM_W(NUM_W)
    ) resolver_i (
        .top_req(top_req), .grp_req(grp_req), .dma_req(dma_req),
        .hit(res_hit), .num(res_num)
    );

    // Register the resolved answer for the processor side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_num   <= '1;
        end else begin
            irq_valid <= res_hit;
            irq_num   <= res_hit ? res_num : '1;
        end
    end
endmodule

// File: rtl/cic_checker.sv
// Module: property checker for the cascaded interrupt controller.
// Does: watches ports and bank state; attached to the top by bind.
// Assumes: inputs are known from the first clock.
module cic_checker
    import cic_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_GRP = 4,
    parameter int NUM_DMA = 6,
    parameter int NUM_END = 176,
    parameter int NUM_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic [NUM_DMA-1:0] dma_src,
    input logic [NUM_DMA-1:0] dma_pend,
    input logic [NUM_DMA-1:0] dma_en,
    input logic [DATA_W-1:0]  top_en,
    input logic [NUM_GRP-1:0] grp_en_any,
    input logic               irq_valid,
    input logic [NUM_W-1:0]   irq_num
);
    localparam logic [ADDR_W-1:0] A_DMA_SET = {OP_EN_SET, BANK_DMA};
    localparam logic [ADDR_W-1:0] A_DMA_ACK = {OP_ACK, BANK_DMA};

    // R1: first cycle out of reset reports nothing.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !irq_valid);

    // R9: no request means the all-ones code.
    a_r9_none_code: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> irq_num == '1);

    // R4: a reported number lies inside the flat range.
    a_r4_num_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> int'(irq_num) < NUM_END);

    // R2: an enable-set write to the DMA bank turns the written bits on.
    a_r2_dma_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DMA_SET) |=>
        ((dma_en & $past(wr_data[NUM_DMA-1:0])) == $past(wr_data[NUM_DMA-1:0])));

    // R3: acknowledging idle DMA channels clears their pending bits.
    a_r3_dma_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DMA_ACK) |=>
        ((dma_pend & $past(wr_data[NUM_DMA-1:0]) & ~$past(dma_src)) == '0));

    // R8: with every enable off and no write, nothing is reported next cycle.
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (top_en == '0 && grp_en_any == '0 && dma_en == '0 && !wr_en) |=> !irq_valid);
endmodule

bind cascade_irq_ctrl cic_checker #(
    .DATA_W(DATA_W), .NUM_GRP(NUM_GRP), .NUM_DMA(NUM_DMA),
    .NUM_END(NUM_END), .NUM_W(NUM_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dma_src(dma_src), .dma_pend(dma_pend),
    .dma_en(dma_en), .top_en(top_en), .grp_en_any(grp_en_any),
    .irq_valid(irq_valid), .irq_num(irq_num)
);

// File: tb/cascade_irq_ctrl_tb.sv
module cascade_irq_ctrl_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  irq_src = '0;
    logic [5:0]   dma_src = '0;
    logic [127:0] gpio_src = '0;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         irq_valid;
    logic [7:0]   irq_num;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cascade_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .dma_src(dma_src),
        .gpio_src(gpio_src), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_valid(irq_valid), .irq_num(irq_num)
    );

    typedef struct packed {
        logic [7:0]  src;   // flat number pulsed, 255 = none
        logic        wr;
        logic [1:0]  op;
        logic [2:0]  bank;
        logic [31:0] data;
        logic        ev;
        logic [7:0]  en;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{8'd255, 1'b1, 2'd0, 3'd1, 32'h4,        1'b0, 8'hFF, 4'd7},  // R7 enable only
        '{8'd34,  1'b0, 2'd0, 3'd0, 32'h0,        1'b1, 8'd34, 4'd7},  // R7
        '{8'd33,  1'b1, 2'd0, 3'd1, 32'h2,        1'b1, 8'd33, 4'd7},  // R7 lowest channel
        '{8'd255, 1'b1, 2'd2, 3'd1, 32'h2,        1'b1, 8'd34, 4'd3},  // R3 ack
        '{8'd255, 1'b1, 2'd2, 3'd1, 32'h4,        1'b0, 8'hFF, 4'd9},  // R9
        '{8'd5,   1'b0, 2'd0, 3'd0, 32'h0,        1'b0, 8'hFF, 4'd3},  // R3 masked
        '{8'd255, 1'b1, 2'd0, 3'd0, 32'h20,       1'b1, 8'd5,  4'd4},  // R4
        '{8'd50,  1'b1, 2'd0, 3'd2, 32'h4,        1'b1, 8'd5,  4'd5},  // R5
        '{8'd255, 1'b1, 2'd2, 3'd0, 32'h20,       1'b1, 8'd50, 4'd6},  // R6
        '{8'd151, 1'b1, 2'd0, 3'd5, 32'h80,       1'b1, 8'd151,4'd6},  // R6 group 3
        '{8'd255, 1'b1, 2'd2, 3'd5, 32'h80,       1'b1, 8'd50, 4'd11}, // R11
        '{8'd34,  1'b0, 2'd0, 3'd0, 32'h0,        1'b1, 8'd34, 4'd5},  // R5 line 20
        '{8'd255, 1'b1, 2'd1, 3'd1, 32'h4,        1'b1, 8'd50, 4'd2},  // R2 clear
        '{8'd255, 1'b1, 2'd3, 3'd1, 32'h4,        1'b1, 8'd50, 4'd2},  // R2 op 3
        '{8'd255, 1'b1, 2'd0, 3'd0, 32'h00100000, 1'b1, 8'd50, 4'd8},  // R8
        '{8'd255, 1'b1, 2'd2, 3'd0, 32'h10000000, 1'b1, 8'd50, 4'd8},  // R8
        '{8'd255, 1'b1, 2'd2, 3'd2, 32'h4,        1'b0, 8'hFF, 4'd11}, // R11
        '{8'd48,  1'b1, 2'd0, 3'd6, 32'hFFFFFFFF, 1'b0, 8'hFF, 4'd2},  // R2 bank 6
        '{8'd255, 1'b1, 2'd0, 3'd2, 32'h1,        1'b1, 8'd48, 4'd6},  // R6 pin 0
        '{8'd255, 1'b1, 2'd2, 3'd2, 32'h1,        1'b0, 8'hFF, 4'd9},  // R9
        '{8'd0,   1'b1, 2'd0, 3'd0, 32'h1,        1'b1, 8'd0,  4'd4},  // R4 index 0
        '{8'd255, 1'b1, 2'd2, 3'd0, 32'h1,        1'b0, 8'hFF, 4'd9}   // R9
    };

    task automatic chk(input string tag, input logic ev, input logic [7:0] en);
        checks++;
        if (irq_valid !== ev || irq_num !== en) begin
            failures++;
            $display("FAIL %s actual valid=%0b num=%0d expected valid=%0b num=%0d",
                     tag, irq_valid, irq_num, ev, en);
        end
    endtask

    task automatic set_src(input int n, input logic v);
        if (n < 32) irq_src[n] = v;
        else if (n < 38) dma_src[n-32] = v;
        else if (n >= 48 && n < 176) gpio_src[n-48] = v;
    endtask

    task automatic do_write(input logic [1:0] op, input logic [2:0] bank, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {op, bank}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            failures++;
            $display("FAIL R10 watchdog actual=%0d cycles expected=done", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", 1'b0, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 1'b0, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_src(int'(VECS[i].src), 1'b1);
            @(negedge clk);
            set_src(int'(VECS[i].src), 1'b0);
            if (VECS[i].wr) begin
                wr_en = 1'b1; wr_addr = {VECS[i].op, VECS[i].bank}; wr_data = VECS[i].data;
            end
            @(negedge clk);
            wr_en = 1'b0; wr_data = '0;
            @(negedge clk);
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].ev, VECS[i].en);
        end

        // R10: a source sampled at one edge shows up only after the next edge.
        do_write(2'd0, 3'd0, 32'h8);
        irq_src[3] = 1'b1;
        @(negedge clk);
        chk("R10 not yet visible", 1'b0, 8'hFF);
        @(negedge clk);
        chk("R10 visible", 1'b1, 8'd3);

        // R3: acknowledge while the source is still high leaves it pending.
        do_write(2'd2, 3'd0, 32'h8);
        @(negedge clk);
        chk("R3 ack with live source", 1'b1, 8'd3);
        irq_src[3] = 1'b0;
        do_write(2'd2, 3'd0, 32'h8);
        @(negedge clk);
        chk("R3 ack after release", 1'b0, 8'hFF);

        // R1: reset in mid-run clears the enables.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        irq_src[3] = 1'b1;
        @(negedge clk);
        irq_src[3] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 enables cleared", 1'b0, 8'hFF);

        finish_run();
    end
endmodule